// File: doc/BRIEF.md
# Modulator Overload Monitor with Recovery Counter

This block watches the single-bit output of the first stage of a delta-sigma modulator and sorts the analog input into one of three ranges. The input is normal while the modulator is within its full-scale ones density. It is overdriven when the density has moved past full scale but the stream still toggles. It is saturated when the stream has gone to a constant level. The density is taken over a sliding window of the most recent strobed bits, kept as a running count of ones. The block also reports whether an overload sits on the positive or the negative side.

The decimating filter that follows the modulator delays the return of valid results, because of its group delay. For that reason the block also counts the filter's output-reading strobes once the input is back in range. A first flag marks readings that are within the linear range again. A second flag marks readings that are fully settled. Any new overload clears both counts and starts them again. Downstream logic uses the two flags to qualify or discard conversion results.

Top module: `mod_ovr_monitor`

## Requirements
- R1: While reset is held and on the first cycle after it, `ovr_o`, `sat_o`, `ovr_neg_o`, `lin_o` and `settled_o` are all low.
- R2: The ones count covers exactly the last WIN_BITS (default 256) bits that were presented with `bit_vld_i` high. A value on `bit_i` without the strobe has no effect on any output.
- R3: With a full window, a ones count from LO_LIM to HI_LIM inclusive is normal, and `ovr_o` and `sat_o` are both low. HI_LIM = floor(WIN_BITS*90/100) = 230 and LO_LIM = floor(WIN_BITS*10/100) = 25.
- R4: With a full window, a ones count above HI_LIM but below WIN_BITS, or below LO_LIM but above zero, gives `ovr_o` = 1 and `sat_o` = 0.
- R5: With a full window, a count of WIN_BITS (all ones) or of zero (all zeros) gives `sat_o` = 1 and `ovr_o` = 0.
- R6: `ovr_neg_o` is high exactly when the window is full and its count is below LO_LIM, which covers both overdrive and saturation on the negative side. It is low otherwise.
- R7: Until WIN_BITS strobed bits have been received since reset, the range is reported as normal.
- R8: In every cycle in which `ovr_o` or `sat_o` is high, `lin_o` and `settled_o` are low.
- R9: `lin_o` goes high at the 31st reading strobe counted while the range is normal, and `settled_o` goes high at the 62nd. Both then stay high until the next overload. This also applies from reset.
- R10: A new overload restarts both counts from zero, so that after it ends a full 31 or 62 readings are needed again.
- R11: Reading strobes that arrive while an overload is present are not counted.
- R12: The range flags fall on the same bit strobe that brings the ones count back inside the normal limits, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | First-stage modulator output bit |
| bit_vld_i | input | 1 | Strobe marking a new modulator bit on `bit_i` |
| rd_stb_i | input | 1 | Strobe for one filter output reading |
| ovr_o | output | 1 | Overdriven but still modulating |
| sat_o | output | 1 | Saturated: window all ones or all zeros |
| ovr_neg_o | output | 1 | Overload lies on the negative side |
| lin_o | output | 1 | Readings are back within the linear range |
| settled_o | output | 1 | Readings are fully settled |

## Verification
The properties assume that the range flags can only move on a cycle after a bit strobe, and that the recovery flags can only rise on a cycle after a reading strobe. They therefore require both strobes to be plain single-cycle qualifiers with no meaning outside the cycle in which they are high. The stimulus raises each strobe for whole clock periods at the falling edge and never changes `bit_i` in a way that the design could pick up without the strobe. The bench steps the window to exact counts by filling it from reset with known runs of ones and zeros, so the expected count at every sample is known precisely. This includes the counts one either side of each limit.

// File: rtl/ovr_mon_pkg.sv
package ovr_mon_pkg;

   typedef enum logic [1:0] {
      RNG_NORMAL = 2'd0,
      RNG_OVER   = 2'd1,
      RNG_SAT    = 2'd2
   } rng_e;

   typedef struct packed {
      rng_e cls;
      logic neg;
   } rng_t;

endpackage

// File: rtl/ovr_density_win.sv
module ovr_density_win #(
   parameter int WIN_BITS = 256,
   parameter int CW       = $clog2(WIN_BITS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_i,
   input  logic          vld_i,
   output logic [CW-1:0] ones_o,
   output logic          full_o
);

   localparam logic [CW-1:0] WIN_CNT = CW'(WIN_BITS);

   logic [WIN_BITS-1:0] tap_q;
   logic [CW-1:0]       ones_q;
   logic [CW-1:0]       fill_q;
   logic                oldest;

   // bit leaving the window; zero until the window has wrapped once
   assign oldest = tap_q[WIN_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_q <= '0;
      end else if (vld_i) begin
         tap_q <= {tap_q[WIN_BITS-2:0], bit_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q <= '0;
      end else if (vld_i) begin
         ones_q <= ones_q + CW'(bit_i) - CW'(oldest);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= '0;
      end else if (vld_i && (fill_q != WIN_CNT)) begin
         fill_q <= fill_q + 1'b1;
      end
   end

   assign ones_o = ones_q;
   assign full_o = (fill_q == WIN_CNT);

endmodule

// File: rtl/ovr_range_class.sv
module ovr_range_class
   import ovr_mon_pkg::*;
#(
   parameter int WIN_BITS = 256,
   parameter int CW       = $clog2(WIN_BITS + 1),
   parameter int HI_LIM   = 230,
   parameter int LO_LIM   = 25
) (
   input  logic [CW-1:0] ones_i,
   input  logic          full_i,
   output rng_t          rng_o
);

   localparam logic [CW-1:0] ALL_ONES = CW'(WIN_BITS);
   localparam logic [CW-1:0] HI_CMP   = CW'(HI_LIM);
   localparam logic [CW-1:0] LO_CMP   = CW'(LO_LIM);

   always_comb begin
      rng_o.cls = RNG_NORMAL;
      rng_o.neg = 1'b0;
      if (full_i) begin
         if (ones_i == '0) begin
            rng_o.cls = RNG_SAT;
            rng_o.neg = 1'b1;
         end else if (ones_i == ALL_ONES) begin
            rng_o.cls = RNG_SAT;
         end else if (ones_i > HI_CMP) begin
            rng_o.cls = RNG_OVER;
         end else if (ones_i < LO_CMP) begin
            rng_o.cls = RNG_OVER;
            rng_o.neg = 1'b1;
         end
      end
   end

endmodule

// File: rtl/ovr_settle_cnt.sv
module ovr_settle_cnt #(
   parameter int LIN_READS = 31,
   parameter int SET_READS = 62
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic rd_i,
   output logic lin_o,
   output logic settled_o
);

   localparam int SW = $clog2(SET_READS + 1);
   localparam logic [SW-1:0] LIN_CNT = SW'(LIN_READS);
   localparam logic [SW-1:0] SET_CNT = SW'(SET_READS);

   logic [SW-1:0] rd_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_cnt_q <= '0;
      end else if (hold_i) begin
         rd_cnt_q <= '0;
      end else if (rd_i && (rd_cnt_q != SET_CNT)) begin
         rd_cnt_q <= rd_cnt_q + 1'b1;
      end
   end

   // an overload masks the flags in the same cycle the counter is cleared
   assign lin_o     = !hold_i && (rd_cnt_q >= LIN_CNT);
   assign settled_o = !hold_i && (rd_cnt_q >= SET_CNT);

endmodule

// File: rtl/mod_ovr_monitor.sv
module mod_ovr_monitor
   import ovr_mon_pkg::*;
#(
   parameter int WIN_BITS  = 256,
   parameter int HI_PCT    = 90,
   parameter int LO_PCT    = 10,
   parameter int LIN_READS = 31,
   parameter int SET_READS = 62
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_i,
   input  logic bit_vld_i,
   input  logic rd_stb_i,
   output logic ovr_o,
   output logic sat_o,
   output logic ovr_neg_o,
   output logic lin_o,
   output logic settled_o
);

   localparam int CW     = $clog2(WIN_BITS + 1);
   localparam int HI_LIM = (WIN_BITS * HI_PCT) / 100;
   localparam int LO_LIM = (WIN_BITS * LO_PCT) / 100;

   generate
      if (WIN_BITS < 8) begin : g_bad_win
         $error("WIN_BITS must be at least 8");
      end
      if ((HI_PCT >= 100) || (LO_PCT <= 0) || (LO_PCT >= HI_PCT)) begin : g_bad_pct
         $error("thresholds need 0 < LO_PCT < HI_PCT < 100");
      end
      if ((LO_LIM < 1) || (HI_LIM >= WIN_BITS)) begin : g_bad_lim
         $error("window too short to separate overdrive from saturation");
      end
      if ((LIN_READS < 1) || (SET_READS <= LIN_READS)) begin : g_bad_reads
         $error("need 0 < LIN_READS < SET_READS");
      end
   endgenerate

   logic [CW-1:0] ones;
   logic          full;
   rng_t          rng;
   logic          hold;

   ovr_density_win #(
      .WIN_BITS (WIN_BITS),
      .CW       (CW)
   ) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_i  (bit_i),
      .vld_i  (bit_vld_i),
      .ones_o (ones),
      .full_o (full)
   );

   ovr_range_class #(
      .WIN_BITS (WIN_BITS),
      .CW       (CW),
      .HI_LIM   (HI_LIM),
      .LO_LIM   (LO_LIM)
   ) u_cls (
      .ones_i (ones),
      .full_i (full),
      .rng_o  (rng)
   );

   assign hold = (rng.cls != RNG_NORMAL);

   ovr_settle_cnt #(
      .LIN_READS (LIN_READS),
      .SET_READS (SET_READS)
   ) u_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_i    (hold),
      .rd_i      (rd_stb_i),
      .lin_o     (lin_o),
      .settled_o (settled_o)
   );

   assign ovr_o     = (rng.cls == RNG_OVER);
   assign sat_o     = (rng.cls == RNG_SAT);
   assign ovr_neg_o = rng.neg;

endmodule

// File: rtl/ovr_mon_chk.sv
module ovr_mon_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_vld_i,
   input logic rd_stb_i,
   input logic ovr_o,
   input logic sat_o,
   input logic ovr_neg_o,
   input logic lin_o,
   input logic settled_o
);

   // R2
   range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bit_vld_i) |-> ($stable(ovr_o) && $stable(sat_o) && $stable(ovr_neg_o)));

   // R5
   range_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovr_o && sat_o));

   // R6
   neg_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_neg_o |-> (ovr_o || sat_o));

   // R8
   overload_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_o || sat_o) |-> (!lin_o && !settled_o));

   // R9
   settle_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      settled_o |-> lin_o);

   // R9
   lin_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lin_o) |-> $past(rd_stb_i));

   // R9
   settled_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(settled_o) |-> $past(rd_stb_i));

endmodule

bind mod_ovr_monitor ovr_mon_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_vld_i (bit_vld_i),
   .rd_stb_i  (rd_stb_i),
   .ovr_o     (ovr_o),
   .sat_o     (sat_o),
   .ovr_neg_o (ovr_neg_o),
   .lin_o     (lin_o),
   .settled_o (settled_o)
);

// File: tb/mod_ovr_monitor_bench.sv
`timescale 1ns/1ps
module mod_ovr_monitor_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_i = 1'b0;
   logic bit_vld_i = 1'b0;
   logic rd_stb_i = 1'b0;
   logic ovr_o, sat_o, ovr_neg_o, lin_o, settled_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mod_ovr_monitor u_mod_ovr_monitor (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_i     (bit_i),
      .bit_vld_i (bit_vld_i),
      .rd_stb_i  (rd_stb_i),
      .ovr_o     (ovr_o),
      .sat_o     (sat_o),
      .ovr_neg_o (ovr_neg_o),
      .lin_o     (lin_o),
      .settled_o (settled_o)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic range_is(input string req, input logic e_ovr, input logic e_sat, input logic e_neg);
      check(req, "ovr_o", ovr_o, e_ovr);
      check(req, "sat_o", sat_o, e_sat);
      check(req, "ovr_neg_o", ovr_neg_o, e_neg);
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0; bit_vld_i = 1'b0; rd_stb_i = 1'b0; bit_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic push(input logic b);
      @(negedge clk);
      bit_i = b; bit_vld_i = 1'b1; rd_stb_i = 1'b0;
   endtask

   task automatic push_run(input logic b, input int n);
      for (int i = 0; i < n; i++) push(b);
   endtask

   task automatic quiet;
      @(negedge clk);
      bit_vld_i = 1'b0; rd_stb_i = 1'b0;
   endtask

   task automatic reads(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bit_vld_i = 1'b0; rd_stb_i = 1'b1;
      end
      quiet();
   endtask

   // reset state, partial window, saturation high side, ignored bits and reads
   task automatic t_reset_and_sat;
      do_reset();
      range_is("R1", 1'b0, 1'b0, 1'b0);
      check("R1", "lin_o", lin_o, 1'b0);
      check("R1", "settled_o", settled_o, 1'b0);
      push_run(1'b1, 255);
      quiet();
      range_is("R7", 1'b0, 1'b0, 1'b0);
      push(1'b1);
      quiet();
      range_is("R5", 1'b0, 1'b1, 1'b0);
      check("R8", "lin_o", lin_o, 1'b0);
      bit_i = 1'b0;
      repeat (12) @(negedge clk);
      range_is("R2", 1'b0, 1'b1, 1'b0);
      reads(70);
      check("R11", "lin_o", lin_o, 1'b0);
      check("R11", "settled_o", settled_o, 1'b0);
   endtask

   // reads from reset with no overload, then density patterns
   task automatic t_patterns;
      do_reset();
      reads(61);
      check("R9", "settled_o at 61", settled_o, 1'b0);
      check("R9", "lin_o at 61", lin_o, 1'b1);
      reads(1);
      check("R9", "settled_o at 62", settled_o, 1'b1);
      for (int i = 0; i < 256; i++) push(logic'(i % 2));
      quiet();
      range_is("R3", 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 256; i++) push(logic'((i % 20) != 0));
      quiet();
      range_is("R4", 1'b1, 1'b0, 1'b0);
      check("R8", "settled_o", settled_o, 1'b0);
      for (int i = 0; i < 256; i++) push(logic'((i % 20) == 0));
      quiet();
      range_is("R6", 1'b1, 1'b0, 1'b1);
   endtask

   // exact high limit
   task automatic t_high_edge;
      do_reset();
      push_run(1'b0, 26);
      push_run(1'b1, 230);
      quiet();
      range_is("R3", 1'b0, 1'b0, 1'b0);
      push(1'b1);
      quiet();
      range_is("R4", 1'b1, 1'b0, 1'b0);
   endtask

   // exact low limit, down into negative saturation and back out
   task automatic t_low_edge;
      do_reset();
      push_run(1'b1, 25);
      push_run(1'b0, 231);
      quiet();
      range_is("R3", 1'b0, 1'b0, 1'b0);
      push(1'b0);
      quiet();
      range_is("R6", 1'b1, 1'b0, 1'b1);
      push_run(1'b0, 23);
      quiet();
      range_is("R4", 1'b1, 1'b0, 1'b1);
      push(1'b0);
      quiet();
      range_is("R5", 1'b0, 1'b1, 1'b1);
      push(1'b1);
      quiet();
      range_is("R4", 1'b1, 1'b0, 1'b1);
   endtask

   // recovery counts, restart on new overload
   task automatic t_recover;
      do_reset();
      push_run(1'b1, 256);
      push_run(1'b0, 25);
      quiet();
      range_is("R4", 1'b1, 1'b0, 1'b0);
      push(1'b0);
      quiet();
      range_is("R12", 1'b0, 1'b0, 1'b0);
      reads(30);
      check("R9", "lin_o at 30", lin_o, 1'b0);
      reads(1);
      check("R9", "lin_o at 31", lin_o, 1'b1);
      check("R9", "settled_o at 31", settled_o, 1'b0);
      reads(30);
      check("R9", "settled_o at 61", settled_o, 1'b0);
      reads(1);
      check("R9", "settled_o at 62", settled_o, 1'b1);
      reads(10);
      check("R9", "settled_o held", settled_o, 1'b1);
      push_run(1'b0, 206);
      quiet();
      range_is("R10", 1'b1, 1'b0, 1'b1);
      check("R10", "lin_o cleared", lin_o, 1'b0);
      check("R10", "settled_o cleared", settled_o, 1'b0);
      push_run(1'b1, 25);
      quiet();
      range_is("R12", 1'b0, 1'b0, 1'b0);
      reads(30);
      check("R10", "lin_o after 30 new", lin_o, 1'b0);
      reads(1);
      check("R10", "lin_o after 31 new", lin_o, 1'b1);
   endtask

   initial begin
      t_reset_and_sat();
      t_patterns();
      t_high_edge();
      t_low_edge();
      t_recover();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule